// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

The block turns a fast system clock into a one-cycle enable that marks each period of a clock at sixteen times the serial bit rate. A small prescaler divides the input clock by 1, 3, 4 or 5. A second counter then divides that result by a ratio taken from a fixed table. The table holds plain integer ratios, three thirds-based ratios and a pass-through entry. With the common crystal frequencies and a matching prescale, the prescaler output is a steady 614.4 kHz, and the table then spans 38.4k down to 50 baud.

The thirds-based ratios rotate through three integer lengths whose sum is the full numerator, so the average period over three ticks is exact. A clock-out pin carries either the input clock or a square wave at the 16x rate, chosen by the top bit of the select byte. A new select value takes effect only at the end of the 16x period in progress, so no period is ever cut short.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high `tick16_o` stays low. Reset restarts both counters, so the first tick appears exactly P input cycles after reset falls, where P is the prescale ratio times the current divisor length.
- R2: Select bits [1:0] set the prescale ratio: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 5. The tick interval is the prescale ratio times the divisor length.
- R3: Select bits [6:2] hold a divisor index. The integer entries are 1→2, 2→4, 4→8, 6→16, 8→22, 9→32, 10→64, 11→128, 12→192, 13→256, 14→288, 15→352, 16→512 and 17→768. Integer periods of two or more cycles give isolated one-cycle ticks.
- R4: Index 3 (16/3) gives lengths 5,5,6 in turn, index 5 (32/3) gives 10,11,11 and index 7 (58/3) gives 19,19,20, each multiplied by the prescale ratio. The rotation starts at its first length when the index is newly applied.
- R5: Index 0 is pass-through, with a divisor length of 1. With prescale 1 the tick is high on every cycle.
- R6: When select bit 7 is 0, `clk_out_o` follows `clk`. When it is 1, `clk_out_o` carries the 16x square wave, which is high for half of each even-length period. In pass-through with prescale 1 it follows `clk` in either case.
- R7: Reset clears select bit 7 only. The prescale and divisor fields keep their values through reset.
- R8: A select write made during a 16x period leaves that period's length unchanged. The new ratios apply from the next period onward.
- R9: Indices 18 to 31 behave like index 17 (divide by 768).
- R10: In pass-through with prescale 3 the clock-out wave is high for 1 of every 3 cycles. With prescale 5 it is high for 2 of every 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, the source for every division |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Write strobe for the select byte; it is accepted during reset too |
| sel_data | input | 8 | Select byte: [1:0] prescale code, [6:2] divisor index, [7] clock-out choice |
| tick16_o | output | 1 | One-cycle enable at the end of each 16x period |
| clk_out_o | output | 1 | Input clock or the 16x square wave |

## Verification
A counter that wraps at the wrong value shows up as a wrong tick spacing in the first full period after the setting is applied. That can take as long as 768 prescaled cycles. A fault in the thirds rotation shows in one of the three spacings that follow a change of index. A fault in the select latching shows as a shortened period straight after a write. A clock-out mux fault is visible within one half cycle of the input clock. A wrong half-period compare shows as a wrong high-cycle count over a whole number of periods.

// File: rtl/baudgen_pkg.sv
`timescale 1ns/1ps
package baudgen_pkg;
    localparam int PRE_CODE_W = 2;
    localparam int DIV_IDX_W  = 5;
    localparam int PRE_CNT_W  = 3;
    localparam int DIV_CNT_W  = 10;
    localparam int PH_W       = 2;
    localparam int SEL_W      = 1 + DIV_IDX_W + PRE_CODE_W;

    function automatic logic [PRE_CNT_W-1:0] pre_len(input logic [PRE_CODE_W-1:0] code);
        case (code)
            2'd0:    return PRE_CNT_W'(1);
            2'd1:    return PRE_CNT_W'(3);
            2'd2:    return PRE_CNT_W'(4);
            default: return PRE_CNT_W'(5);
        endcase
    endfunction

    function automatic logic is_frac(input logic [DIV_IDX_W-1:0] idx);
        return (idx == 5'd3) || (idx == 5'd5) || (idx == 5'd7);
    endfunction

    // length of the current divisor step; thirds entries rotate by phase
    function automatic logic [DIV_CNT_W-1:0] div_len(input logic [DIV_IDX_W-1:0] idx,
                                                     input logic [PH_W-1:0] ph);
        case (idx)
            5'd0:    return DIV_CNT_W'(1);
            5'd1:    return DIV_CNT_W'(2);
            5'd2:    return DIV_CNT_W'(4);
            5'd3:    return (ph == 2'd2) ? DIV_CNT_W'(6) : DIV_CNT_W'(5);
            5'd4:    return DIV_CNT_W'(8);
            5'd5:    return (ph == 2'd0) ? DIV_CNT_W'(10) : DIV_CNT_W'(11);
            5'd6:    return DIV_CNT_W'(16);
            5'd7:    return (ph == 2'd2) ? DIV_CNT_W'(20) : DIV_CNT_W'(19);
            5'd8:    return DIV_CNT_W'(22);
            5'd9:    return DIV_CNT_W'(32);
            5'd10:   return DIV_CNT_W'(64);
            5'd11:   return DIV_CNT_W'(128);
            5'd12:   return DIV_CNT_W'(192);
            5'd13:   return DIV_CNT_W'(256);
            5'd14:   return DIV_CNT_W'(288);
            5'd15:   return DIV_CNT_W'(352);
            5'd16:   return DIV_CNT_W'(512);
            default: return DIV_CNT_W'(768);
        endcase
    endfunction

    typedef struct packed {
        logic                  sel_co;
        logic [DIV_IDX_W-1:0]  sel_div;
        logic [PRE_CODE_W-1:0] sel_pre;
        logic [DIV_IDX_W-1:0]  act_div;
        logic [PRE_CODE_W-1:0] act_pre;
        logic                  tick;
        logic                  lvl;
    } top_st_t;
endpackage

// File: rtl/bg_prescale_ctr.sv
`timescale 1ns/1ps
module bg_prescale_ctr
    import baudgen_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PRE_CODE_W-1:0] code,
    output logic [PRE_CNT_W-1:0]  cnt_o,
    output logic                  tc_o
);
    logic [PRE_CNT_W-1:0] cnt_d, cnt_q;
    logic [PRE_CNT_W-1:0] len;

    always_comb begin
        len   = pre_len(code);
        tc_o  = (cnt_q == len - PRE_CNT_W'(1));
        cnt_d = tc_o ? '0 : cnt_q + PRE_CNT_W'(1);
        if (rst) cnt_d = '0;
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;

    assign cnt_o = cnt_q;
endmodule

// File: rtl/bg_divisor_ctr.sv
`timescale 1ns/1ps
module bg_divisor_ctr
    import baudgen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic [DIV_IDX_W-1:0] idx,
    input  logic                 keep_idx,
    output logic [DIV_CNT_W-1:0] cnt_o,
    output logic [DIV_CNT_W-1:0] len_o,
    output logic                 tc_o
);
    typedef struct packed {
        logic [DIV_CNT_W-1:0] cnt;
        logic [PH_W-1:0]      ph;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        len_o = div_len(idx, st_q.ph);
        tc_o  = step && (st_q.cnt == len_o - DIV_CNT_W'(1));
        if (step) st_d.cnt = tc_o ? '0 : st_q.cnt + DIV_CNT_W'(1);
        if (tc_o) begin
            if (keep_idx && is_frac(idx))
                st_d.ph = (st_q.ph == 2'd2) ? 2'd0 : st_q.ph + 2'd1;
            else
                st_d.ph = 2'd0;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
    import baudgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_data,
    output logic             tick16_o,
    output logic             clk_out_o
);
    top_st_t st_d, st_q;

    logic [PRE_CNT_W-1:0] pcnt;
    logic                 pre_tc;
    logic [DIV_CNT_W-1:0] dcnt;
    logic [DIV_CNT_W-1:0] dlen;
    logic                 div_tc;
    logic                 keep_idx;
    logic                 pass_thru;
    logic [DIV_IDX_W-1:0] act_div_cur;
    logic                 co_sel_cur;

    assign act_div_cur = st_q.act_div;
    assign co_sel_cur  = st_q.sel_co;
    assign keep_idx    = (st_q.sel_div == st_q.act_div);
    assign pass_thru   = (st_q.act_pre == '0) && (act_div_cur == '0);

    bg_prescale_ctr u_pre (
        .clk   (clk),
        .rst   (rst),
        .code  (st_q.act_pre),
        .cnt_o (pcnt),
        .tc_o  (pre_tc)
    );

    bg_divisor_ctr u_div (
        .clk      (clk),
        .rst      (rst),
        .step     (pre_tc),
        .idx      (act_div_cur),
        .keep_idx (keep_idx),
        .cnt_o    (dcnt),
        .len_o    (dlen),
        .tc_o     (div_tc)
    );

    always_comb begin
        st_d = st_q;
        if (sel_wr) {st_d.sel_co, st_d.sel_div, st_d.sel_pre} = sel_data;
        if (rst) begin
            st_d.sel_co  = 1'b0;
            st_d.act_pre = st_d.sel_pre;
            st_d.act_div = st_d.sel_div;
            st_d.tick    = 1'b0;
            st_d.lvl     = 1'b0;
        end else begin
            st_d.tick = div_tc;
            // high half of the period, taken from the stage that sets its length
            if (act_div_cur == '0)
                st_d.lvl = (pcnt < (pre_len(st_q.act_pre) >> 1));
            else
                st_d.lvl = (dcnt < (dlen >> 1));
            if (div_tc) begin
                st_d.act_pre = st_q.sel_pre;
                st_d.act_div = st_q.sel_div;
            end
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign tick16_o  = st_q.tick;
    assign clk_out_o = (co_sel_cur && !pass_thru) ? st_q.lvl : clk;
endmodule

// File: rtl/baud_tick_gen_chk.sv
`timescale 1ns/1ps
module baud_tick_gen_chk
    import baudgen_pkg::*;
#(
    parameter int GAP_LIMIT = 5 * 768
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick16_o,
    input logic                 pass_thru,
    input logic [DIV_IDX_W-1:0] act_div_cur,
    input logic                 co_sel_cur
);
    localparam int GW = $clog2(GAP_LIMIT + 1);
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || tick16_o) gap_q <= '0;
        else                 gap_q <= gap_q + GW'(1);
    end

    // R2: ticks never drift apart by more than the slowest setting allows
    a_r2_gap_bound: assert property (@(posedge clk) disable iff (rst)
        gap_q < GW'(GAP_LIMIT));

    // R3: outside pass-through a tick never lasts two cycles
    a_r3_single_tick: assert property (@(posedge clk) disable iff (rst)
        (tick16_o && !pass_thru) |=> !tick16_o);

    // R7: clock-out select is clear on the first cycle after reset
    a_r7_co_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !co_sel_cur);

    // R8: applied divisor changes only together with a tick
    a_r8_change_at_tc: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(act_div_cur)) |-> tick16_o);
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick16_o    (tick16_o),
    .pass_thru   (pass_thru),
    .act_div_cur (act_div_cur),
    .co_sel_cur  (co_sel_cur)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_wr = 1'b0;
    logic [7:0] sel_data = 8'h00;
    logic       tick16_o;
    logic       clk_out_o;
    int         n_chk = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk       (clk),
        .rst       (rst),
        .sel_wr    (sel_wr),
        .sel_data  (sel_data),
        .tick16_o  (tick16_o),
        .clk_out_o (clk_out_o)
    );

    function automatic logic [7:0] mk(input bit co, input int idx, input int pre);
        return {co, 5'(idx), 2'(pre)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick16_o);
    endtask

    task automatic configure(input logic [7:0] v);
        while (!tick16_o) @(negedge clk);
        sel_wr   = 1'b1;
        sel_data = v;
        @(negedge clk);
        sel_wr = 1'b0;
        do @(negedge clk); while (!tick16_o);
    endtask

    task automatic expect_gap(input logic [7:0] v, input int exp, input string req);
        int n;
        configure(v);
        measure(n);
        chk(n == exp, req, n, exp);
    endtask

    task automatic follow_clk(input string req);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #5;
            chk(clk_out_o == 1'b1, req, int'(clk_out_o), 1);
            @(negedge clk); #1;
            chk(clk_out_o == 1'b0, req, int'(clk_out_o), 0);
        end
    endtask

    task automatic duty(input int cycles, input int exp, input string req);
        int hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (clk_out_o) hi++;
        end
        chk(hi == exp, req, hi, exp);
    endtask

    task automatic t_first_tick;
        int n;
        @(negedge clk);
        sel_wr = 1'b1; sel_data = mk(1, 1, 2);
        @(negedge clk);
        sel_wr = 1'b0;
        chk(tick16_o == 1'b0, "R1 tick low in reset", int'(tick16_o), 0);
        rst = 1'b0;
        measure(n);
        chk(n == 8, "R1 first tick latency", n, 8);
    endtask

    task automatic t_prescale;
        expect_gap(mk(0, 2, 1), 12, "R2 prescale 3");
        expect_gap(mk(0, 2, 3), 20, "R2 prescale 5");
        expect_gap(mk(0, 4, 2), 32, "R2 prescale 4");
    endtask

    task automatic t_integer;
        expect_gap(mk(0, 1, 0), 2,   "R3 index 1");
        expect_gap(mk(0, 6, 0), 16,  "R3 index 6");
        expect_gap(mk(0, 8, 0), 22,  "R3 index 8");
        expect_gap(mk(0, 12, 0), 192, "R3 index 12");
    endtask

    task automatic frac_seq(input logic [7:0] v, input int a, input int b, input int c);
        int n;
        configure(v);
        measure(n); chk(n == a, "R4 thirds step 1", n, a);
        measure(n); chk(n == b, "R4 thirds step 2", n, b);
        measure(n); chk(n == c, "R4 thirds step 3", n, c);
    endtask

    task automatic t_frac;
        frac_seq(mk(0, 3, 0), 5, 5, 6);
        frac_seq(mk(0, 5, 0), 10, 11, 11);
        frac_seq(mk(0, 7, 1), 57, 57, 60);
    endtask

    task automatic t_bypass;
        int hi = 0;
        configure(mk(0, 0, 0));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tick16_o) hi++;
        end
        chk(hi == 8, "R5 bypass tick continuous", hi, 8);
        expect_gap(mk(0, 0, 3), 5, "R5 bypass prescale 5");
    endtask

    task automatic t_clkout;
        configure(mk(0, 2, 0));
        follow_clk("R6 select 0 follows clk");
        configure(mk(1, 1, 0));
        duty(40, 20, "R6 square wave duty");
        configure(mk(1, 0, 0));
        follow_clk("R6 pass-through follows clk");
    endtask

    task automatic t_bypass_duty;
        configure(mk(1, 0, 1));
        duty(30, 10, "R10 prescale 3 duty");
        configure(mk(1, 0, 3));
        duty(50, 20, "R10 prescale 5 duty");
    endtask

    task automatic t_switch;
        int n;
        configure(mk(0, 2, 0));
        sel_wr = 1'b1; sel_data = mk(0, 4, 0);
        n = 0;
        do begin
            @(negedge clk);
            sel_wr = 1'b0;
            n++;
        end while (!tick16_o);
        chk(n == 4, "R8 running period kept", n, 4);
        measure(n);
        chk(n == 8, "R8 new ratio next period", n, 8);
    endtask

    task automatic t_reserved;
        expect_gap(mk(0, 31, 0), 768, "R9 index 31");
    endtask

    task automatic t_reset_keep;
        int n;
        configure(mk(1, 1, 2));
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(tick16_o == 1'b0, "R1 tick low in reset", int'(tick16_o), 0);
        end
        rst = 1'b0;
        measure(n);
        chk(n == 8, "R1 restart latency", n, 8);
        measure(n);
        chk(n == 8, "R7 fields kept through reset", n, 8);
        follow_clk("R7 clock-out select cleared");
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_first_tick();
        t_prescale();
        t_integer();
        t_frac();
        t_bypass();
        t_clkout();
        t_bypass_duty();
        t_switch();
        t_reserved();
        t_reset_keep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule